// File: doc/BRIEF.md
# Hamming SEC/DED Codec

This block protects a data word with a Hamming code extended by one overall parity bit. One bit error per word is corrected and any two errors are detected. The write path turns a data word into a stored codeword. The read path takes a stored codeword and returns four things: the repaired data, the syndrome, a flag for a corrected single error, and a flag for an uncorrectable error. The default configuration protects 64 data bits with 8 check bits. The same RTL, set to 4 data bits, builds an 8-bit codeword.

Inside the codeword the Hamming check bits sit at the power-of-two positions. A nonzero syndrome is therefore the 1-based position of a single flipped bit. The overall parity bit tells a single error apart from a double error. Both paths are combinational into one output register stage, so results appear one clock after the inputs are presented.

Top module: `hsd_codec`

## Requirements
- R1: With DATA_W=64 the codeword is 72 bits. Bit 0 holds the overall parity, and bits 1..71 are Hamming positions 1..71. Check bits sit at positions 1, 2, 4, 8, 16, 32 and 64. Data bit i fills the i-th position that is not a power of two, in ascending order (data bit 0 to position 3, bit 1 to 5, bit 2 to 6, bit 3 to 7, bit 4 to 9).
- R2: The check bit at position 2^k is the XOR of every other Hamming position whose index has bit k set. The overall parity bit makes the XOR of all codeword bits equal to zero.
- R3: An error-free codeword decodes to its data, with syndrome 0 and both flags low.
- R4: A single flipped bit at Hamming position p (1..71) gives syndrome p and the original data, with the single flag high and the double flag low.
- R5: A flip of only the overall parity bit (bit 0) gives syndrome 0, unchanged data and the single flag high.
- R6: Two flipped bits raise the double flag and leave the single flag low. The syndrome is the XOR of the flipped Hamming positions, and the data output is the received data field with no correction.
- R7: A syndrome greater than the last Hamming position (71 for 64 data bits) raises the double flag, and the data passes through uncorrected.
- R8: The single and double flags are never high together.
- R9: All outputs are registered and reflect the inputs one clock after they are sampled. While rst_n is low every output is zero.
- R10: With DATA_W=4 the codeword is 8 bits (3 Hamming check bits plus overall parity) and follows R1 to R6. For example, data 4'b1001 encodes to 8'h99.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_data_i | input | DATA_W | Data word to encode |
| enc_code_o | output | CW (72) | Encoded codeword |
| dec_code_i | input | CW (72) | Received codeword to decode |
| dec_data_o | output | DATA_W | Corrected (or passed-through) data |
| dec_syndrome_o | output | HW (7) | Hamming syndrome |
| dec_single_o | output | 1 | Single error corrected |
| dec_double_o | output | 1 | Uncorrectable error detected |

## Verification
The bench flips every codeword bit in turn, including the overall parity bit. A design that numbers positions off by one, or that places a data bit at a power-of-two position, then repairs the wrong bit and shows a wrong syndrome. Bit pairs that include the overall parity bit catch a decoder that trusts parity alone and "corrects" a double error. A triple flip whose syndrome points past position 71 catches a decoder that skips the range check and reports a single error. An exhaustive sweep of the 4-bit configuration catches an encoder whose check coverage is tied to the 64-bit layout.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

  // Smallest E with 2^E >= W + E + 1 (single error correction bound).
  function automatic int chk_bits(input int w);
    for (int e = 1; e < 31; e++) begin
      if ((1 << e) >= w + e + 1) return e;
    end
    return 31;
  endfunction

  function automatic bit is_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // Hamming position (1-based) of data bit i: i-th non-power-of-two index.
  function automatic int data_pos(input int i);
    int cnt;
    cnt = 0;
    for (int p = 1; p <= 2 * i + 8; p++) begin
      if (!is_pow2(p)) begin
        if (cnt == i) return p;
        cnt++;
      end
    end
    return 0;
  endfunction

  // True when Hamming position p is covered by check bit k.
  function automatic bit covers(input int p, input int k);
    return ((p >> k) & 1) == 1;
  endfunction

endpackage

// File: rtl/hsd_encoder.sv
module hsd_encoder
  import hsd_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW-1:0]                    data,
  output logic [DW+chk_bits(DW):0]         code
);
  localparam int HW = chk_bits(DW);
  localparam int NH = DW + HW;

  // Data scattered to its Hamming positions; check slots and bit 0 are zero.
  logic [NH:0] placed;

  generate
    for (genvar gp = 0; gp <= NH; gp++) begin : g_slot
      if (gp == 0 || is_pow2(gp)) begin : g_empty
        assign placed[gp] = 1'b0;
      end
    end
    for (genvar gi = 0; gi < DW; gi++) begin : g_place
      assign placed[data_pos(gi)] = data[gi];
    end
  endgenerate

  logic [HW-1:0] chk;
  always_comb begin
    for (int k = 0; k < HW; k++) begin
      chk[k] = 1'b0;
      for (int p = 1; p <= NH; p++) begin
        if (covers(p, k)) chk[k] = chk[k] ^ placed[p];
      end
    end
  end

  logic [NH:0] full;
  always_comb begin
    full = placed;
    for (int k = 0; k < HW; k++) full[1 << k] = chk[k];
    full[0] = ^full[NH:1];
  end

  assign code = full;

endmodule

// File: rtl/hsd_syndrome.sv
module hsd_syndrome
  import hsd_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW+chk_bits(DW):0]  code,
  output logic [chk_bits(DW)-1:0]   syn,
  output logic                      par_err
);
  localparam int HW = chk_bits(DW);
  localparam int NH = DW + HW;

  always_comb begin
    for (int k = 0; k < HW; k++) begin
      syn[k] = 1'b0;
      for (int p = 1; p <= NH; p++) begin
        if (covers(p, k)) syn[k] = syn[k] ^ code[p];
      end
    end
  end

  assign par_err = ^code;

endmodule

// File: rtl/hsd_corrector.sv
module hsd_corrector
  import hsd_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [DW+chk_bits(DW):0]  code,
  input  logic [chk_bits(DW)-1:0]   syn,
  input  logic                      par_err,
  output logic [DW-1:0]             data_corr,
  output logic [DW-1:0]             data_raw,
  output logic                      single,
  output logic                      double,
  output logic                      beyond
);
  localparam int HW = chk_bits(DW);
  localparam int NH = DW + HW;

  logic nz;
  logic do_fix;
  logic [NH:0] fixed;

  assign nz     = |syn;
  assign beyond = int'(syn) > NH;
  assign single = par_err && !beyond;
  assign double = (nz && !par_err) || beyond;
  assign do_fix = single && nz;

  always_comb begin
    fixed = code;
    for (int p = 1; p <= NH; p++) begin
      if (do_fix && (int'(syn) == p)) fixed[p] = ~code[p];
    end
  end

  generate
    for (genvar gi = 0; gi < DW; gi++) begin : g_gather
      assign data_corr[gi] = fixed[data_pos(gi)];
      assign data_raw[gi]  = code[data_pos(gi)];
    end
  endgenerate

endmodule

// File: rtl/hsd_codec.sv
module hsd_codec
  import hsd_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [DATA_W-1:0]              enc_data_i,
  output logic [DATA_W+chk_bits(DATA_W):0] enc_code_o,
  input  logic [DATA_W+chk_bits(DATA_W):0] dec_code_i,
  output logic [DATA_W-1:0]              dec_data_o,
  output logic [chk_bits(DATA_W)-1:0]    dec_syndrome_o,
  output logic                           dec_single_o,
  output logic                           dec_double_o
);
  localparam int HW = chk_bits(DATA_W);
  localparam int CW = DATA_W + HW + 1;

  // Named internal events, also observed by the bound checker.
  logic [CW-1:0]     enc_code_w;
  logic [HW-1:0]     syn_w;
  logic              par_err_w;
  logic [DATA_W-1:0] corr_w;
  logic [DATA_W-1:0] raw_w;
  logic              single_w;
  logic              double_w;
  logic              beyond_w;

  hsd_encoder #(.DW(DATA_W)) u_enc (
    .data (enc_data_i),
    .code (enc_code_w)
  );

  hsd_syndrome #(.DW(DATA_W)) u_syn (
    .code    (dec_code_i),
    .syn     (syn_w),
    .par_err (par_err_w)
  );

  hsd_corrector #(.DW(DATA_W)) u_fix (
    .code      (dec_code_i),
    .syn       (syn_w),
    .par_err   (par_err_w),
    .data_corr (corr_w),
    .data_raw  (raw_w),
    .single    (single_w),
    .double    (double_w),
    .beyond    (beyond_w)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          enc_code_o     <= '0;
          dec_data_o     <= '0;
          dec_syndrome_o <= '0;
          dec_single_o   <= 1'b0;
          dec_double_o   <= 1'b0;
        end else begin
          enc_code_o     <= enc_code_w;
          dec_data_o     <= corr_w;
          dec_syndrome_o <= syn_w;
          dec_single_o   <= single_w;
          dec_double_o   <= double_w;
        end
      end
    end else begin : g_comb
      assign enc_code_o     = enc_code_w;
      assign dec_data_o     = corr_w;
      assign dec_syndrome_o = syn_w;
      assign dec_single_o   = single_w;
      assign dec_double_o   = double_w;
    end
  endgenerate

endmodule

// File: rtl/hsd_codec_chk.sv
module hsd_codec_chk
  import hsd_pkg::*;
#(
  parameter int DW      = 64,
  parameter bit REG_OUT = 1'b1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [DW+chk_bits(DW):0] enc_code,
  input logic [chk_bits(DW)-1:0]  syn,
  input logic                     par_err,
  input logic [DW-1:0]            corr,
  input logic [DW-1:0]            raw,
  input logic                     single,
  input logic                     double,
  input logic [DW-1:0]            data_o,
  input logic [chk_bits(DW)-1:0]  syn_o,
  input logic                     single_o,
  input logic                     double_o
);
  localparam int NH = DW + chk_bits(DW);

  p_enc_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (^enc_code) == 1'b0);

  p_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (syn == '0 && !par_err) |-> (!single && !double && corr == raw));

  p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (single && syn != '0) |-> ($countones(corr ^ raw) <= 1));

  p_parity_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (syn == '0 && par_err) |-> (single && corr == raw));

  p_double_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (syn != '0 && !par_err) |-> (double && !single && corr == raw));

  p_beyond_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(syn) > NH) |-> (double && corr == raw));

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(single_o && double_o));

  generate
    if (REG_OUT) begin : g_lat
      p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (data_o == $past(corr) && syn_o == $past(syn) &&
                  single_o == $past(single) && double_o == $past(double)));
    end
  endgenerate

endmodule

bind hsd_codec hsd_codec_chk #(.DW(DATA_W), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enc_code (enc_code_w),
  .syn      (syn_w),
  .par_err  (par_err_w),
  .corr     (corr_w),
  .raw      (raw_w),
  .single   (single_w),
  .double   (double_w),
  .data_o   (dec_data_o),
  .syn_o    (dec_syndrome_o),
  .single_o (dec_single_o),
  .double_o (dec_double_o)
);

// File: tb/hsd_codec_tb.sv
`timescale 1ns/1ps
module hsd_codec_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [63:0] enc_data = '0;
  logic [71:0] enc_code;
  logic [71:0] dec_code = '0;
  logic [63:0] dec_data;
  logic [6:0]  dec_syn;
  logic        dec_single, dec_double;

  logic [3:0]  s_enc_data = '0;
  logic [7:0]  s_enc_code;
  logic [7:0]  s_dec_code = '0;
  logic [3:0]  s_dec_data;
  logic [2:0]  s_dec_syn;
  logic        s_single, s_double;

  hsd_codec #(.DATA_W(64)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .enc_data_i(enc_data), .enc_code_o(enc_code),
    .dec_code_i(dec_code), .dec_data_o(dec_data),
    .dec_syndrome_o(dec_syn), .dec_single_o(dec_single), .dec_double_o(dec_double)
  );

  hsd_codec #(.DATA_W(4)) u_dut_small (
    .clk(clk), .rst_n(rst_n),
    .enc_data_i(s_enc_data), .enc_code_o(s_enc_code),
    .dec_code_i(s_dec_code), .dec_data_o(s_dec_data),
    .dec_syndrome_o(s_dec_syn), .dec_single_o(s_single), .dec_double_o(s_double)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  task automatic expect_eq(input string req, input logic [71:0] act, input logic [71:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model, written from the requirement text.
  function automatic int m_pos(input int i);
    int p, seen;
    p = 0; seen = -1;
    while (seen < i) begin
      p++;
      if ((p & (p - 1)) != 0) seen++;
    end
    return p;
  endfunction

  function automatic logic [71:0] m_enc(input logic [63:0] d, input int w);
    logic [71:0] c;
    int nh;
    nh = w + ((w == 64) ? 7 : 3);
    c = '0;
    for (int i = 0; i < w; i++) c[m_pos(i)] = d[i];
    for (int k = 0; (1 << k) <= nh; k++) begin
      logic acc;
      acc = 1'b0;
      for (int p = 1; p <= nh; p++) if (p[k]) acc ^= c[p];
      c[1 << k] = acc;
    end
    for (int p = 1; p <= nh; p++) c[0] ^= c[p];
    return c;
  endfunction

  function automatic logic [63:0] m_raw(input logic [71:0] c, input int w);
    logic [63:0] d;
    d = '0;
    for (int i = 0; i < w; i++) d[i] = c[m_pos(i)];
    return d;
  endfunction

  task automatic drive64(input logic [63:0] d, input logic [71:0] c);
    @(negedge clk);
    enc_data = d;
    dec_code = c;
    @(posedge clk);
    #1;
  endtask

  task automatic dec64(input string req, input logic [71:0] c, input logic [63:0] ed,
                       input logic [6:0] es, input logic esg, input logic edb);
    drive64('0, c);
    expect_eq({req, " data"}, 72'(dec_data), 72'(ed));
    expect_eq({req, " syndrome"}, 72'(dec_syn), 72'(es));
    expect_eq({req, " single"}, 72'(dec_single), 72'(esg));
    expect_eq({req, " double"}, 72'(dec_double), 72'(edb));
    expect_eq("R8 flags exclusive", 72'(dec_single & dec_double), 72'(0));
  endtask

  task automatic t_reset;
    enc_data = 64'hFFFF_FFFF_FFFF_FFFF;
    dec_code = 72'h1;
    @(posedge clk); #1;
    expect_eq("R9 reset enc", enc_code, '0);
    expect_eq("R9 reset data", 72'(dec_data), '0);
    expect_eq("R9 reset syn/flags", 72'({dec_syn, dec_single, dec_double}), '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_layout;
    drive64(64'h1, '0);
    expect_eq("R1 data bit0 layout", enc_code, 72'hF);
    drive64(64'h10, '0);
    expect_eq("R1 data bit4 layout", enc_code, 72'h303);
  endtask

  task automatic t_encode;
    logic [63:0] pats [5];
    pats[0] = 64'h0;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'hDEAD_BEEF_0123_4567;
    pats[3] = 64'h8000_0000_0000_0001;
    pats[4] = 64'hA5A5_5A5A_F0F0_0F0F;
    for (int i = 0; i < 5; i++) begin
      drive64(pats[i], m_enc(pats[i], 64));
      expect_eq("R2 encode", enc_code, m_enc(pats[i], 64));
      expect_eq("R3 clean data", 72'(dec_data), 72'(pats[i]));
      expect_eq("R3 clean flags", 72'({dec_syn, dec_single, dec_double}), '0);
    end
  endtask

  task automatic t_single;
    logic [63:0] d;
    logic [71:0] c;
    d = 64'h0F1E_2D3C_4B5A_6978;
    c = m_enc(d, 64);
    for (int p = 1; p <= 71; p++) begin
      dec64("R4 single flip", c ^ (72'h1 << p), d, 7'(p), 1'b1, 1'b0);
    end
    dec64("R5 parity bit flip", c ^ 72'h1, d, 7'd0, 1'b1, 1'b0);
  endtask

  task automatic t_double;
    logic [63:0] d;
    logic [71:0] c, b;
    int pa [4];
    int pb [4];
    d = 64'h1357_9BDF_2468_ACE0;
    c = m_enc(d, 64);
    pa[0] = 1;  pb[0] = 2;
    pa[1] = 3;  pb[1] = 71;
    pa[2] = 0;  pb[2] = 5;
    pa[3] = 40; pb[3] = 41;
    for (int i = 0; i < 4; i++) begin
      b = c ^ (72'h1 << pa[i]) ^ (72'h1 << pb[i]);
      dec64("R6 double flip", b, m_raw(b, 64), 7'(pa[i] ^ pb[i]), 1'b0, 1'b1);
    end
  endtask

  task automatic t_beyond;
    logic [63:0] d;
    logic [71:0] c, b;
    d = 64'hCAFE_F00D_1234_5678;
    c = m_enc(d, 64);
    b = c ^ (72'h1 << 64) ^ (72'h1 << 8) ^ (72'h1 << 1);
    dec64("R7 syndrome 73", b, m_raw(b, 64), 7'd73, 1'b0, 1'b1);
    b = c ^ (72'h1 << 64) ^ (72'h1 << 32) ^ (72'h1 << 16);
    dec64("R7 syndrome 112", b, m_raw(b, 64), 7'd112, 1'b0, 1'b1);
  endtask

  task automatic t_small;
    logic [7:0] c;
    @(negedge clk);
    s_enc_data = 4'b1001;
    @(posedge clk); #1;
    expect_eq("R10 small known code", 72'(s_enc_code), 72'h99);
    for (int v = 0; v < 16; v++) begin
      c = m_enc(64'(v), 4)[7:0];
      for (int p = -1; p <= 7; p++) begin
        @(negedge clk);
        s_enc_data = 4'(v);
        s_dec_code = (p < 0) ? c : (c ^ (8'h1 << p));
        @(posedge clk); #1;
        if (p < 0) begin
          expect_eq("R10 small encode", 72'(s_enc_code), 72'(c));
          expect_eq("R10 small clean", 72'({s_dec_data, s_dec_syn, s_single, s_double}),
                    72'({4'(v), 3'd0, 2'b00}));
        end else begin
          expect_eq("R10 small single", 72'({s_dec_data, s_dec_syn, s_single, s_double}),
                    72'({4'(v), 3'(p), 2'b10}));
        end
      end
    end
    c = m_enc(64'd6, 4)[7:0] ^ 8'h06;
    @(negedge clk);
    s_dec_code = c;
    @(posedge clk); #1;
    expect_eq("R10 small double", 72'({s_dec_data, s_dec_syn, s_single, s_double}),
              72'({4'(m_raw(72'(c), 4)), 3'd3, 2'b01}));
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_layout();
    t_encode();
    t_single();
    t_double();
    t_beyond();
    t_small();
    finished = 1'b1;
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      report();
    end
  end

endmodule